// File: doc/BRIEF.md
# Clock Supervisor with Safe-Oscillator Fallback

This block watches a main clock from a free-running safe oscillator that is always present, and it chooses which of the two drives the core clock. When the main clock stops, the core moves to the slow safe clock so that recovery code can still run. When the main clock returns and runs steadily again, the core moves back without any software step. Each changeover goes through a two-stage enable handshake, so the core clock never carries a runt pulse.

A failover sets a sticky flag. Software clears the flag with a write-one-to-clear strobe. An interrupt request is the flag gated by an enable. On the main clock path sits a spike filter, clocked by a fast reference. The filter removes high or low phases shorter than a set minimum, and it works only while the PLL-enable input is high. With that input low, the main clock passes through untouched. Main-clock activity reaches the safe domain as a small Gray-coded edge counter through a two-flop synchronizer. The main clock must make fewer than 2^GRAY_W edges in one safe period.

The inputs `irq_en` and `flag_clr` are synchronous to `safe_clk`.

Top module: `clkguard_top`

## Requirements
- R1: While reset is asserted and right after it, `sel_safe`, `fail_flag` and `irq` are 0, and the core clock follows the main clock.
- R2: If no main-clock edge is seen for LOSS_CYC (default 8) consecutive safe-clock periods, `sel_safe` goes to 1 and the core clock then runs at the safe-clock rate.
- R3: A main-clock pause that lasts clearly less than LOSS_CYC safe periods does not change the selection.
- R4: While on the safe clock, REC_CYC (default 16) consecutive safe periods that each contain a main-clock edge return `sel_safe` to 0 and the core clock to the main rate. A safe period without an edge restarts this count.
- R5: The two clock legs are never enabled at the same time. The old leg's enable drops before the new leg's enable rises.
- R6: `fail_flag` is set in every safe cycle in which `sel_safe` is 1. It stays set after the core returns to the main clock. A one-cycle pulse on `flag_clr` clears it only while `sel_safe` is 0, because a set wins over a clear.
- R7: `irq` equals `fail_flag` AND `irq_en`, so it stays high until the flag is cleared or the enable is dropped.
- R8: With `pll_en` at 1, a main-clock phase shorter than MIN_PHASE (default 3) reference periods is suppressed and counts as no activity. A main clock whose phases are longer still passes.
- R9: With `pll_en` at 0, the main clock reaches the detector and the core unfiltered, so even short pulses count as main-clock activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock for the spike filter |
| main_clk | input | 1 | Main clock being supervised |
| safe_clk | input | 1 | Always-running low-frequency safe clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | Enables spike filtering on the main path |
| irq_en | input | 1 | Interrupt enable (safe_clk domain) |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag (safe_clk domain) |
| core_clk | output | 1 | Glitch-free selected core clock |
| sel_safe | output | 1 | 1 while the core is switched to the safe clock |
| fail_flag | output | 1 | Sticky clock-failure flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a main clock that is dead in frequency but not electrically quiet. The main source is stopped and then fed only short spikes, a few nanoseconds wide, every 100 ns. The stimulus holds this pattern first with `pll_en` high, where the block must stay on the safe clock. It then holds the same pattern with `pll_en` low, where the spikes must count as activity and bring the core back. Interrupted recoveries and pauses just under the loss window come from random run/stop phases. The length of each phase is held at least a few safe periods away from either threshold, so the expected selection is unambiguous.

// File: rtl/clkguard_pkg.sv
`timescale 1ns/1ps
package clkguard_pkg;
   typedef enum logic { SRC_MAIN = 1'b0, SRC_SAFE = 1'b1 } clk_src_e;

   // width of a counter that must hold values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/cg_spike_filter.sv
`timescale 1ns/1ps
module cg_spike_filter #(
   parameter int MIN_PHASE = 3,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic pll_en,
   input  logic clk_in,
   output logic clk_out
);
   import clkguard_pkg::*;

   if (MIN_PHASE < 2) begin : g_bad_min
      $error("cg_spike_filter: MIN_PHASE must be at least 2");
   end

   generate
      if (FILTER_EN) begin : g_filter
         localparam int RW = cnt_width(MIN_PHASE);
         logic          y1_q, y2_q, filt_q;
         logic [RW-1:0] run_q;

         always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n) begin
               y1_q   <= 1'b0;
               y2_q   <= 1'b0;
               filt_q <= 1'b0;
               run_q  <= '0;
            end else begin
               y1_q <= clk_in;
               y2_q <= y1_q;
               if (y2_q == filt_q) begin
                  run_q <= '0;
               end else if (run_q == RW'(MIN_PHASE - 1)) begin
                  filt_q <= y2_q;
                  run_q  <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end

         assign clk_out = pll_en ? filt_q : clk_in;

         // R8: an accepted level was already present on the previous sample
         a_r8_level_held: assert property (@(posedge ref_clk) disable iff (!rst_n)
            !$stable(filt_q) |-> $past(y2_q) == y2_q);
      end else begin : g_bypass
         assign clk_out = clk_in;
      end
   endgenerate
endmodule

// File: rtl/cg_activity_mon.sv
`timescale 1ns/1ps
module cg_activity_mon #(
   parameter int GRAY_W   = 3,
   parameter int LOSS_CYC = 8,
   parameter int REC_CYC  = 16
) (
   input  logic mclk,
   input  logic sclk,
   input  logic rst_n,
   output logic lost
);
   import clkguard_pkg::*;

   localparam int LW = cnt_width(LOSS_CYC);
   localparam int CW = cnt_width(REC_CYC);

   if (GRAY_W < 1 || LOSS_CYC < 2 || REC_CYC < 2) begin : g_bad_par
      $error("cg_activity_mon: parameter out of range");
   end

   // main-domain Gray edge counter
   logic [GRAY_W-1:0] bin_q, gray_q, bin_nxt;
   assign bin_nxt = bin_q + 1'b1;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_nxt;
         gray_q <= bin_nxt ^ (bin_nxt >> 1);
      end
   end

   // safe-domain synchronizer and change detect
   logic [GRAY_W-1:0] s1_q, s2_q, s3_q;
   logic              act;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= '0;
         s2_q <= '0;
         s3_q <= '0;
      end else begin
         s1_q <= gray_q;
         s2_q <= s1_q;
         s3_q <= s2_q;
      end
   end
   assign act = (s2_q != s3_q);

   // loss and recovery decisions
   logic [LW-1:0] sil_q;
   logic [CW-1:0] rec_q;
   logic          lost_q;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         sil_q  <= '0;
         rec_q  <= '0;
         lost_q <= 1'b0;
      end else begin
         if (act) begin
            sil_q <= '0;
         end else if (sil_q != LW'(LOSS_CYC)) begin
            sil_q <= sil_q + 1'b1;
         end

         if (!lost_q) begin
            rec_q <= '0;
            if (!act && sil_q == LW'(LOSS_CYC - 1)) begin
               lost_q <= 1'b1;
            end
         end else if (act) begin
            if (rec_q == CW'(REC_CYC - 1)) begin
               lost_q <= 1'b0;
               rec_q  <= '0;
            end else begin
               rec_q <= rec_q + 1'b1;
            end
         end else begin
            rec_q <= '0;
         end
      end
   end

   assign lost = lost_q;

   // R2: failover only follows a period without activity
   a_r2_loss_needs_silence: assert property (@(posedge sclk) disable iff (!rst_n)
      $rose(lost_q) |-> !$past(act));
   // R4: return only follows a period with activity
   a_r4_return_needs_activity: assert property (@(posedge sclk) disable iff (!rst_n)
      $fell(lost_q) |-> $past(act));
endmodule

// File: rtl/cg_clk_switch.sv
`timescale 1ns/1ps
module cg_clk_switch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic mclk,
   input  logic sclk,
   input  logic rst_n,
   input  logic use_safe,
   output logic core_clk,
   output logic main_on,
   output logic safe_on
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cg_clk_switch: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] m_sh_q, s_sh_q;
   logic                   m_rst;

   // a dead main clock cannot clock its own enable off: clear it asynchronously
   assign m_rst = !rst_n || use_safe;

   always_ff @(negedge mclk or posedge m_rst) begin
      if (m_rst) m_sh_q <= '0;
      else       m_sh_q <= {m_sh_q[SYNC_STAGES-2:0], !use_safe && !safe_on};
   end

   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n) s_sh_q <= '0;
      else        s_sh_q <= {s_sh_q[SYNC_STAGES-2:0], use_safe && !main_on};
   end

   assign main_on  = m_sh_q[SYNC_STAGES-1];
   assign safe_on  = s_sh_q[SYNC_STAGES-1];
   assign core_clk = (mclk & main_on) | (sclk & safe_on);

   // R5: the two legs never drive the core together
   always_comb begin
      if (rst_n) begin
         a_r5_legs_exclusive: assert (!(main_on && safe_on));
      end
   end
endmodule

// File: rtl/clkguard_top.sv
`timescale 1ns/1ps
module clkguard_top #(
   parameter int MIN_PHASE = 3,
   parameter bit FILTER_EN = 1'b1,
   parameter int GRAY_W    = 3,
   parameter int LOSS_CYC  = 8,
   parameter int REC_CYC   = 16
) (
   input  logic ref_clk,
   input  logic main_clk,
   input  logic safe_clk,
   input  logic rst_n,
   input  logic pll_en,
   input  logic irq_en,
   input  logic flag_clr,
   output logic core_clk,
   output logic sel_safe,
   output logic fail_flag,
   output logic irq
);
   import clkguard_pkg::*;

   logic     main_fil, lost, main_on, safe_on, flag_q;
   clk_src_e src;

   cg_spike_filter #(.MIN_PHASE(MIN_PHASE), .FILTER_EN(FILTER_EN)) u_filt (
      .ref_clk(ref_clk), .rst_n(rst_n), .pll_en(pll_en),
      .clk_in(main_clk), .clk_out(main_fil));

   cg_activity_mon #(.GRAY_W(GRAY_W), .LOSS_CYC(LOSS_CYC), .REC_CYC(REC_CYC)) u_mon (
      .mclk(main_fil), .sclk(safe_clk), .rst_n(rst_n), .lost(lost));

   assign src = lost ? SRC_SAFE : SRC_MAIN;

   cg_clk_switch #(.SYNC_STAGES(2)) u_sw (
      .mclk(main_fil), .sclk(safe_clk), .rst_n(rst_n),
      .use_safe(src == SRC_SAFE), .core_clk(core_clk),
      .main_on(main_on), .safe_on(safe_on));

   always_ff @(posedge safe_clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (lost)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign sel_safe  = (src == SRC_SAFE);
   assign fail_flag = flag_q;
   assign irq       = flag_q & irq_en;

   // R6: the flag is raised while on the safe clock
   a_r6_flag_on_loss: assert property (@(posedge safe_clk) disable iff (!rst_n)
      lost |=> flag_q);
   // R6: without a clear strobe the flag holds
   a_r6_flag_sticky: assert property (@(posedge safe_clk) disable iff (!rst_n)
      flag_q && !flag_clr |=> flag_q);
   // R6: a clear while on the main clock takes effect
   a_r6_clear_works: assert property (@(posedge safe_clk) disable iff (!rst_n)
      flag_clr && !lost |=> !flag_q);
endmodule

// File: tb/clkguard_top_tb.sv
`timescale 1ns/1ps
module clkguard_top_tb;
   logic ref_clk = 1'b0, safe_clk = 1'b0, gen_clk = 1'b0, spike = 1'b0;
   logic rst_n = 1'b0, pll_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
   logic main_run = 1'b0;
   logic main_clk, core_clk, sel_safe, fail_flag, irq;
   int   n_chk = 0, n_bad = 0, core_edges = 0;
   bit   done = 1'b0;

   assign main_clk = gen_clk | spike;

   clkguard_top u_dut (
      .ref_clk(ref_clk), .main_clk(main_clk), .safe_clk(safe_clk), .rst_n(rst_n),
      .pll_en(pll_en), .irq_en(irq_en), .flag_clr(flag_clr),
      .core_clk(core_clk), .sel_safe(sel_safe), .fail_flag(fail_flag), .irq(irq));

   always #4   ref_clk  = ~ref_clk;   // 125 MHz
   always #100 safe_clk = ~safe_clk;  // 5 MHz safe oscillator

   initial begin : main_gen
      forever begin
         if (main_run) #32 gen_clk = ~gen_clk;
         else begin gen_clk = 1'b0; #4; end
      end
   end

   always @(posedge core_clk) core_edges++;

   function automatic logic exp_sel(input logic prev, input logic run, input logic long_ph);
      return long_ph ? !run : prev;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_safe(input int n);
      repeat (n) @(negedge safe_clk);
   endtask

   task automatic core_count(output int n);
      int c0;
      c0 = core_edges;
      wait_safe(10);
      n = core_edges - c0;
   endtask

   task automatic pulse_clr();
      @(negedge safe_clk) flag_clr = 1'b1;
      @(negedge safe_clk) flag_clr = 1'b0;
   endtask

   task automatic spikes(input int n);
      for (int i = 0; i < n; i++) begin
         #96 spike = 1'b1;
         #4  spike = 1'b0;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge ref_clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int  n;
      logic exp_s;
      void'($urandom(32'h5eed_c10c));
      main_run = 1'b1;
      wait_safe(3);
      check("R1 sel_safe in reset", sel_safe, 0);
      check("R1 fail_flag in reset", fail_flag, 0);
      check("R1 irq in reset", irq, 0);
      @(negedge safe_clk) rst_n = 1'b1;
      wait_safe(5);
      check("R1 sel_safe after reset", sel_safe, 0);
      core_count(n);
      check_rng("R1 core runs at main rate", n, 28, 34);

      // R3: short pause, no failover
      main_run = 1'b0; wait_safe(3); main_run = 1'b1;
      wait_safe(6);
      check("R3 short pause keeps main", sel_safe, 0);
      check("R3 no flag after short pause", fail_flag, 0);

      // R2 + R6 + R7: loss
      main_run = 1'b0;
      wait_safe(20);
      check("R2 loss selects safe", sel_safe, 1);
      check("R6 flag set on loss", fail_flag, 1);
      check("R7 irq masked when disabled", irq, 0);
      core_count(n);
      check_rng("R2 core at safe rate", n, 9, 11);
      @(negedge safe_clk) irq_en = 1'b1;
      #1 check("R7 irq follows enable", irq, 1);
      pulse_clr();
      wait_safe(1);
      check("R6 clear ignored while on safe", fail_flag, 1);

      // R4: interrupted recovery stays on safe
      main_run = 1'b1; wait_safe(8); main_run = 1'b0; wait_safe(3);
      main_run = 1'b1; wait_safe(8);
      check("R4 interrupted recovery stays safe", sel_safe, 1);
      wait_safe(16);
      check("R4 full recovery returns to main", sel_safe, 0);
      core_count(n);
      check_rng("R4 core back at main rate", n, 28, 34);
      check("R6 flag sticky after recovery", fail_flag, 1);
      check("R7 irq held until clear", irq, 1);
      pulse_clr();
      wait_safe(1);
      check("R6 clear on main", fail_flag, 0);
      check("R7 irq drops with flag", irq, 0);

      // R8: filter active, legit clock passes, spikes rejected
      @(negedge safe_clk) pll_en = 1'b1;
      wait_safe(30);
      check("R8 filtered main clock still accepted", sel_safe, 0);
      main_run = 1'b0;
      wait_safe(20);
      check("R8 loss with filter on", sel_safe, 1);
      spikes(60);
      check("R8 spikes suppressed, stay safe", sel_safe, 1);

      // R9: filter off, spikes count as activity
      @(negedge safe_clk) pll_en = 1'b0;
      spikes(60);
      check("R9 unfiltered spikes recover", sel_safe, 0);

      // random run/stop phases
      pulse_clr();
      main_run = 1'b1; wait_safe(30);
      exp_s = 1'b0;
      for (int p = 0; p < 24; p++) begin
         logic run, lng;
         int   dur;
         run = 1'($urandom % 2);
         lng = 1'($urandom % 2);
         if (lng)      dur = 30 + int'($urandom % 10);
         else if (run) dur = 1 + int'($urandom % 3);
         else          dur = 2 + int'($urandom % 2);
         main_run = run;
         wait_safe(dur);
         exp_s = exp_sel(exp_s, run, lng);
         if (lng) check(run ? "R4 random recovery" : "R2 random loss", sel_safe, exp_s);
         else     check(run ? "R4 random short run" : "R3 random short pause", sel_safe, exp_s);
         check("R7 random irq", irq, fail_flag & irq_en);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule